// File: doc/BRIEF.md
# Thread-Aware Hardware Breakpoint Unit

This block watches the instruction fetch stream of a processor core and raises a breakpoint debug event when a programmed condition is met. It holds six breakpoint slots. Each slot has a value register, holding a word address or a context identifier, and a control register that says how the value is used. Both registers are loaded through a single register-write port. Every valid fetch is compared against all enabled slots in parallel. The per-slot results come out one cycle later as a hit vector, together with a single event flag.

A slot can hit when the fetch address equals its value or when the two differ. The second form lets a debugger single-step by setting a break on every address other than the current one. Slots 4 and 5 can also compare their value against the current context ID. A context-ID slot either fires on its own or serves as the qualifier for an address slot linked to it. A linked address slot fires only when its address condition and the linked context ID both hold in the same fetch, so a thread-specific break does not stop unrelated threads. While the core runs privileged code with monitor-mode debugging active, context-only hits and hits that come from a mismatch comparison are dropped. This keeps the debug monitor from trapping into itself.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, every value and control register is zero, all six slots are disabled, and `hit_vec` and `bkpt_event` are 0.
- R2: A write with `wr_en`=1 stores `wr_data` into the value register (`wr_is_ctrl`=0) or the control register (`wr_is_ctrl`=1) of slot `wr_idx`. A write with `wr_idx` of 6 or 7 changes nothing. The control fields are: bit 0 enable, bits [2:1] mode (0 address-equal, 1 address-differ, 2 context ID, 3 reserved and never hits), bit 3 link, and bits [6:4] the linked slot index.
- R3: In mode 0, a slot hits when bits [31:2] of `fetch_addr` equal bits [31:2] of its value. Bits [1:0] are ignored on both sides.
- R4: In mode 1, a slot hits when bits [31:2] of `fetch_addr` differ from bits [31:2] of its value.
- R5: In mode 2 with the link bit clear, slots 4 and 5 hit when `ctx_id` equals their value. Slots 0 to 3 in mode 2 never hit.
- R6: An address slot (mode 0 or 1) with its link bit set hits only if its address condition holds, the linked index is 4 or 5, that slot is enabled and in mode 2, and `ctx_id` equals that slot's value. In every other case it does not hit.
- R7: A mode-2 slot with its link bit set acts only as a link qualifier and never hits on its own.
- R8: While `priv_mode` and `monitor_mode` are both 1, context-only hits (R5) and every mode-1 hit, linked or not, are suppressed.
- R9: Comparisons happen only on cycles with `fetch_valid`=1. `hit_vec` bit i shows the result for slot i one cycle after the fetch and is 0 after a cycle without a fetch. `bkpt_event` is 1 exactly when `hit_vec` is nonzero.
- R10: A slot whose enable bit is 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_ctrl | input | 1 | 1 selects the control register, 0 selects the value register |
| wr_idx | input | 3 | Slot index of the write |
| wr_data | input | 32 | Write data |
| fetch_valid | input | 1 | Current fetch address is valid |
| fetch_addr | input | 32 | Instruction fetch address |
| ctx_id | input | 32 | Current context ID |
| priv_mode | input | 1 | Core is in a privileged mode |
| monitor_mode | input | 1 | Monitor-mode debugging is active |
| bkpt_event | output | 1 | Registered breakpoint debug event |
| hit_vec | output | 6 | Registered per-slot hit vector |

## Verification
The bench targets the suppression rule. A design that ignored it would break on the monitor's own privileged code, and one that applied it too widely would also drop ordinary equality hits. It checks address bits [1:0] at both ends. A wrong compare width would miss fetches with nonzero low bits or alias neighbouring words. Links are checked against targets that are context-ID incapable, disabled, in the wrong mode, or out of range. A design that trusted the index alone would fire thread-specific breaks for any thread. A context slot used as a link target is checked to make sure it does not also raise an event of its own. A seeded random mix of register writes and fetches then compares the hit vector against a reference model each cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int DEF_NUM_PAIRS = 6;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_CTX_FIRST = 4;
    localparam int IDX_W         = 3;

    typedef enum logic [1:0] {
        MODE_ADDR_EQ = 2'd0,
        MODE_ADDR_NE = 2'd1,
        MODE_CTX     = 2'd2,
        MODE_RSVD    = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] link_idx;
        logic             link_en;
        cmp_mode_e        mode;
        logic             enable;
    } slot_ctrl_t;

    localparam int CTRL_W = $bits(slot_ctrl_t);

    function automatic slot_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] raw);
        return slot_ctrl_t'(raw);
    endfunction

    function automatic logic is_addr_mode(input cmp_mode_e m);
        return (m == MODE_ADDR_EQ) || (m == MODE_ADDR_NE);
    endfunction

endpackage

// File: rtl/bkpt_regbank.sv
module bkpt_regbank
    import bkpt_pkg::*;
#(
    parameter int NUM_PAIRS = DEF_NUM_PAIRS,
    parameter int DATA_W    = DEF_DATA_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic                              wr_is_ctrl,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_PAIRS-1:0][DATA_W-1:0]  val_q,
    output slot_ctrl_t [NUM_PAIRS-1:0]        ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (wr_idx == IDX_W'(p)) begin
                    if (wr_is_ctrl)
                        ctrl_q[p] <= decode_ctrl(wr_data[CTRL_W-1:0]);
                    else
                        val_q[p] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/bkpt_pair_cmp.sv
module bkpt_pair_cmp
    import bkpt_pkg::*;
#(
    parameter int IDX       = 0,
    parameter int NUM_PAIRS = DEF_NUM_PAIRS,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int CTX_FIRST = DEF_CTX_FIRST
) (
    input  logic                              fetch_valid,
    input  logic [DATA_W-1:0]                 fetch_addr,
    input  logic [DATA_W-1:0]                 ctx_id,
    input  logic                              priv_mode,
    input  logic                              monitor_mode,
    input  logic [NUM_PAIRS-1:0][DATA_W-1:0]  val_q,
    input  slot_ctrl_t [NUM_PAIRS-1:0]        ctrl_q,
    output logic                              hit
);

    localparam logic CTX_CAPABLE = (IDX >= CTX_FIRST);

    slot_ctrl_t        own;
    logic              addr_eq;
    logic              tgt_ok;
    logic [DATA_W-1:0] tgt_val;
    logic              cond;
    logic              via_mismatch;
    logic              ctx_only;

    assign own     = ctrl_q[IDX];
    assign addr_eq = (val_q[IDX][DATA_W-1:2] == fetch_addr[DATA_W-1:2]);

    // Pick the linked slot; only context-capable slots in context mode qualify.
    always_comb begin
        tgt_ok  = 1'b0;
        tgt_val = '0;
        for (int j = CTX_FIRST; j < NUM_PAIRS; j++) begin
            if (own.link_idx == IDX_W'(j)) begin
                tgt_ok  = ctrl_q[j].enable && (ctrl_q[j].mode == MODE_CTX);
                tgt_val = val_q[j];
            end
        end
    end

    always_comb begin
        cond         = 1'b0;
        via_mismatch = 1'b0;
        ctx_only     = 1'b0;
        unique case (own.mode)
            MODE_ADDR_EQ: cond = addr_eq;
            MODE_ADDR_NE: begin
                cond         = !addr_eq;
                via_mismatch = 1'b1;
            end
            MODE_CTX: begin
                cond     = CTX_CAPABLE && !own.link_en && (ctx_id == val_q[IDX]);
                ctx_only = 1'b1;
            end
            default: cond = 1'b0;
        endcase
        if (is_addr_mode(own.mode) && own.link_en)
            cond = cond && tgt_ok && (ctx_id == tgt_val);
    end

    assign hit = fetch_valid && own.enable && cond
              && !(priv_mode && monitor_mode && (via_mismatch || ctx_only));

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int NUM_PAIRS = DEF_NUM_PAIRS,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int CTX_FIRST = DEF_CTX_FIRST
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_is_ctrl,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  fetch_valid,
    input  logic [DATA_W-1:0]     fetch_addr,
    input  logic [DATA_W-1:0]     ctx_id,
    input  logic                  priv_mode,
    input  logic                  monitor_mode,
    output logic                  bkpt_event,
    output logic [NUM_PAIRS-1:0]  hit_vec
);

    logic [NUM_PAIRS-1:0][DATA_W-1:0] val_q;
    slot_ctrl_t [NUM_PAIRS-1:0]       ctrl_q;
    logic [NUM_PAIRS-1:0]             hit_next;

    bkpt_regbank #(
        .NUM_PAIRS (NUM_PAIRS),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_is_ctrl (wr_is_ctrl),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .val_q      (val_q),
        .ctrl_q     (ctrl_q)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_slot
        bkpt_pair_cmp #(
            .IDX       (g),
            .NUM_PAIRS (NUM_PAIRS),
            .DATA_W    (DATA_W),
            .CTX_FIRST (CTX_FIRST)
        ) u_cmp (
            .fetch_valid  (fetch_valid),
            .fetch_addr   (fetch_addr),
            .ctx_id       (ctx_id),
            .priv_mode    (priv_mode),
            .monitor_mode (monitor_mode),
            .val_q        (val_q),
            .ctrl_q       (ctrl_q),
            .hit          (hit_next[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vec    <= '0;
            bkpt_event <= 1'b0;
        end else begin
            hit_vec    <= hit_next;
            bkpt_event <= |hit_next;
        end
    end

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk
    import bkpt_pkg::*;
#(
    parameter int NUM_PAIRS = DEF_NUM_PAIRS,
    parameter int CTX_FIRST = DEF_CTX_FIRST
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       fetch_valid,
    input logic                       priv_mode,
    input logic                       monitor_mode,
    input slot_ctrl_t [NUM_PAIRS-1:0] ctrl_q,
    input logic                       bkpt_event,
    input logic [NUM_PAIRS-1:0]       hit_vec
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (hit_vec == '0) && !bkpt_event);

    a_r9_event_tracks_vec: assert property (@(posedge clk) disable iff (rst)
        bkpt_event == (hit_vec != '0));

    a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !$past(fetch_valid) |-> (hit_vec == '0));

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_chk
        a_r10_disabled_silent: assert property (@(posedge clk) disable iff (rst)
            !$past(ctrl_q[i].enable) |-> !hit_vec[i]);

        a_r8_no_mismatch_in_monitor: assert property (@(posedge clk) disable iff (rst)
            $past(priv_mode && monitor_mode && ctrl_q[i].mode == MODE_ADDR_NE)
            |-> !hit_vec[i]);

        a_r7_link_target_silent: assert property (@(posedge clk) disable iff (rst)
            $past(ctrl_q[i].mode == MODE_CTX && ctrl_q[i].link_en) |-> !hit_vec[i]);

        if (i < CTX_FIRST) begin : g_low
            a_r5_low_slot_no_ctx: assert property (@(posedge clk) disable iff (rst)
                $past(ctrl_q[i].mode == MODE_CTX) |-> !hit_vec[i]);
        end
    end

endmodule

bind bkpt_unit bkpt_unit_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .CTX_FIRST (CTX_FIRST)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .priv_mode    (priv_mode),
    .monitor_mode (monitor_mode),
    .ctrl_q       (ctrl_q),
    .bkpt_event   (bkpt_event),
    .hit_vec      (hit_vec)
);

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_is_ctrl = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] ctx_id = '0;
    logic        priv_mode = 1'b0;
    logic        monitor_mode = 1'b0;
    logic        bkpt_event;
    logic [5:0]  hit_vec;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] sh_val  [6];
    logic [6:0]  sh_ctrl [6];

    always #4 clk = ~clk;

    bkpt_unit dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_is_ctrl (wr_is_ctrl),
        .wr_idx (wr_idx), .wr_data (wr_data), .fetch_valid (fetch_valid),
        .fetch_addr (fetch_addr), .ctx_id (ctx_id), .priv_mode (priv_mode),
        .monitor_mode (monitor_mode), .bkpt_event (bkpt_event), .hit_vec (hit_vec)
    );

    // Reference model built from the requirement text.
    function automatic logic [5:0] model(input logic fv, input logic [31:0] a,
                                         input logic [31:0] c, input logic pv,
                                         input logic mn);
        logic [5:0] r = '0;
        for (int i = 0; i < 6; i++) begin
            logic       en   = sh_ctrl[i][0];
            logic [1:0] md   = sh_ctrl[i][2:1];
            logic       ln   = sh_ctrl[i][3];
            int         li   = int'(sh_ctrl[i][6:4]);
            logic       aeq  = (sh_val[i][31:2] == a[31:2]);
            logic       h    = 1'b0;
            logic       supp = 1'b0;
            if (md == 2'd0 || md == 2'd1) begin
                h = (md == 2'd0) ? aeq : !aeq;          // R3 / R4
                if (ln) begin                            // R6
                    if (li >= 4 && li <= 5 && sh_ctrl[li][0] && sh_ctrl[li][2:1] == 2'd2)
                        h = h && (c == sh_val[li]);
                    else
                        h = 1'b0;
                end
                supp = (md == 2'd1);
            end else if (md == 2'd2) begin               // R5 / R7
                h    = (i >= 4) && !ln && (c == sh_val[i]);
                supp = 1'b1;
            end
            if (pv && mn && supp) h = 1'b0;              // R8
            r[i] = fv && en && h;                        // R9 / R10
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp,
                         input logic got_ev);
        checks++;
        if (got !== exp || got_ev !== (exp != 0)) begin
            failures++;
            $display("FAIL %s: hit_vec=%b event=%b expected hit_vec=%b event=%b",
                     req, got, got_ev, exp, (exp != 0));
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic is_ctrl, input logic [2:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_is_ctrl = is_ctrl; wr_idx = idx; wr_data = d;
        fetch_valid = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        if (idx < 3'd6) begin
            if (is_ctrl) sh_ctrl[idx] = d[6:0];
            else         sh_val[idx]  = d;
        end
    endtask

    task automatic fetch(input string req, input logic fv, input logic [31:0] a,
                         input logic [31:0] c, input logic pv, input logic mn,
                         input logic [5:0] directed, input bit use_directed);
        logic [5:0] exp;
        fetch_valid = fv; fetch_addr = a; ctx_id = c; priv_mode = pv; monitor_mode = mn;
        exp = model(fv, a, c, pv, mn);
        @(negedge clk);
        fetch_valid = 1'b0;
        if (use_directed) check({req, " (directed)"}, exp, directed, exp != 0);
        check(req, hit_vec, exp, bkpt_event);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: expired, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] apool [4];
        logic [31:0] cpool [3];
        void'($urandom(32'h1d2c3b4a));
        apool = '{32'h1000, 32'h2000, 32'h4000, 32'h1004};
        cpool = '{32'h55, 32'h77, 32'h78};
        for (int i = 0; i < 6; i++) begin sh_val[i] = '0; sh_ctrl[i] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", hit_vec, 6'b0, bkpt_event);
        fetch("R1 all disabled", 1'b1, 32'h0, 32'h0, 1'b0, 1'b0, 6'b0, 1);

        // R3 equality, low bits ignored
        wr(1'b0, 3'd0, 32'h1003);
        wr(1'b1, 3'd0, 32'h01);
        fetch("R3 eq low bits", 1'b1, 32'h1000, 0, 0, 0, 6'b000001, 1);
        fetch("R3 eq low bits", 1'b1, 32'h1002, 0, 0, 0, 6'b000001, 1);
        fetch("R3 next word", 1'b1, 32'h1004, 0, 0, 0, 6'b000000, 1);
        fetch("R9 no fetch", 1'b0, 32'h1000, 0, 0, 0, 6'b000000, 1);
        fetch("R2 register wrote", 1'b1, 32'h1001, 0, 0, 0, 6'b000001, 1);

        // R4 mismatch and R8 suppression
        wr(1'b0, 3'd1, 32'h2000);
        wr(1'b1, 3'd1, 32'h03);
        fetch("R4 same addr", 1'b1, 32'h2002, 0, 0, 0, 6'b000000, 1);
        fetch("R4 other addr", 1'b1, 32'h3000, 0, 0, 0, 6'b000010, 1);
        fetch("R8 mismatch suppressed", 1'b1, 32'h3000, 0, 1, 1, 6'b000000, 1);
        fetch("R8 priv only", 1'b1, 32'h3000, 0, 1, 0, 6'b000010, 1);
        fetch("R8 eq kept in monitor", 1'b1, 32'h1000, 0, 1, 1, 6'b000001, 1);
        wr(1'b1, 3'd1, 32'h00);

        // R5 context-only
        wr(1'b0, 3'd4, 32'h55);
        wr(1'b1, 3'd4, 32'h05);
        wr(1'b0, 3'd2, 32'h55);
        wr(1'b1, 3'd2, 32'h05);
        fetch("R5 ctx hit", 1'b1, 32'h8000, 32'h55, 0, 0, 6'b010000, 1);
        fetch("R5 ctx miss", 1'b1, 32'h8000, 32'h56, 0, 0, 6'b000000, 1);
        fetch("R8 ctx suppressed", 1'b1, 32'h8000, 32'h55, 1, 1, 6'b000000, 1);
        wr(1'b1, 3'd4, 32'h00);
        wr(1'b1, 3'd2, 32'h00);

        // R6 / R7 linked
        wr(1'b0, 3'd3, 32'h4000);
        wr(1'b1, 3'd3, 32'h59);
        wr(1'b0, 3'd5, 32'h77);
        wr(1'b1, 3'd5, 32'h0D);
        fetch("R6 linked hit", 1'b1, 32'h4000, 32'h77, 0, 0, 6'b001000, 1);
        fetch("R6 wrong ctx", 1'b1, 32'h4000, 32'h78, 0, 0, 6'b000000, 1);
        fetch("R7 target alone", 1'b1, 32'h9000, 32'h77, 0, 0, 6'b000000, 1);
        wr(1'b1, 3'd3, 32'h29);
        fetch("R6 link to low slot", 1'b1, 32'h4000, 32'h77, 0, 0, 6'b000000, 1);
        wr(1'b1, 3'd3, 32'h79);
        fetch("R6 link out of range", 1'b1, 32'h4000, 32'h77, 0, 0, 6'b000000, 1);
        wr(1'b1, 3'd3, 32'h5B);
        fetch("R6 linked mismatch", 1'b1, 32'h5000, 32'h77, 0, 0, 6'b001000, 1);
        fetch("R8 linked mismatch", 1'b1, 32'h5000, 32'h77, 1, 1, 6'b000000, 1);
        wr(1'b1, 3'd5, 32'h0C);
        fetch("R6 target disabled", 1'b1, 32'h5000, 32'h77, 0, 0, 6'b000000, 1);

        // R2 out-of-range writes, R10 disable
        wr(1'b1, 3'd6, 32'h01);
        wr(1'b0, 3'd7, 32'h9000);
        fetch("R2 idx 6/7 ignored", 1'b1, 32'h1000, 0, 0, 0, 6'b000001, 1);
        wr(1'b1, 3'd0, 32'h00);
        fetch("R10 disabled", 1'b1, 32'h1000, 0, 0, 0, 6'b000000, 1);
        wr(1'b1, 3'd0, 32'h07);
        fetch("R2 reserved mode", 1'b1, 32'h1000, 0, 0, 0, 6'b000000, 1);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 9) < 3) begin
                logic [2:0] idx = 3'($urandom_range(0, 7));
                if ($urandom_range(0, 1) == 1)
                    wr(1'b1, idx, $urandom() & 32'h7F);
                else if ($urandom_range(0, 1) == 1)
                    wr(1'b0, idx, apool[$urandom_range(0, 3)] | 32'($urandom_range(0, 3)));
                else
                    wr(1'b0, idx, cpool[$urandom_range(0, 2)]);
            end else begin
                fetch("R9 random", 1'($urandom_range(0, 7) != 0),
                      apool[$urandom_range(0, 3)] | 32'($urandom_range(0, 3)),
                      cpool[$urandom_range(0, 2)], 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 6'b0, 0);
            end
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again", hit_vec, 6'b0, bkpt_event);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule